// File: doc/BRIEF.md
# Hardware Thread Scheduler

This block keeps a table of up to sixteen hardware threads and decides which one runs next. Each table slot holds the thread's program counter, its register window base and a lifecycle state. A thread is placed in the table by a create request. The pipeline then reports what happens to the running thread: a voluntary switch, an end, an instruction cache miss on a given line, or a read of a register whose value has not arrived.

The scheduler parks a thread that missed until the fill for its line completes. It parks a thread that read a missing register until a register-ready wakeup names it. Every other thread that is ready keeps its place in a first-in first-out order. The context of the chosen thread appears on the output ports. A family counter tracks the live threads and raises a done flag when the last one ends. The parent can synchronize on that flag.

The scheduler is used between the fetch stage and the cache and register-file controllers. Those controllers only report events. Every context decision is made here.

Top module: `hts_sched`

## Requirements
- R1: After reset nothing is running (`run_vld`=0), `idle`=1, `fam_done`=0 and `cre_room`=1.
- R2: A create with `cre_vld`=1 takes the lowest-index free slot and makes it ready with the given program counter and window base. When no slot is free, `cre_room` is 0 and the create is ignored.
- R3: While no thread is running and at least one is ready, the thread that has been ready longest is dispatched at the next clock edge. Its id, program counter and window appear on `run_tid`, `run_pc` and `run_win`. Threads that became ready in the same cycle are ordered by lower slot index first.
- R4: A switch tag (`ev_kind`=0) stores `ev_pc` as the resume address and puts the thread at the tail of the ready order. `run_vld` is 0 after the first edge following any event, and the next context is shown after the second edge.
- R5: An end tag (`ev_kind`=1) retires the running thread for good. Its slot becomes free again by the second edge and can be handed to a later create.
- R6: An instruction-miss tag (`ev_kind`=2) parks the thread with resume address `ev_pc` on line `ev_line`. A fill with a matching `fill_line` makes every thread parked on that line ready. A fill on any other line has no effect.
- R7: A register-wait tag (`ev_kind`=3) parks the thread with resume address `ev_pc` until `wake_vld` names it on `wake_tid`. A wakeup for a thread that is not parked on a register has no effect.
- R8: A fill for the same line, or a wakeup for the same thread, that arrives in the same cycle as the miss or register-wait tag makes the thread ready at once.
- R9: `idle` is 1 exactly when no thread is running and none is ready.
- R10: `fam_done` rises one cycle after the end tag of the last live thread. It stays low while other threads remain. It clears on the next accepted create.
- R11: Events presented while no thread is running are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cre_vld | input | 1 | Create a thread |
| cre_pc | input | PCW | Start address of the new thread |
| cre_win | input | WINW | Register window base of the new thread |
| cre_room | output | 1 | A free slot exists |
| ev_vld | input | 1 | Event for the running thread |
| ev_kind | input | 2 | 0 switch, 1 end, 2 instruction miss, 3 register wait |
| ev_pc | input | PCW | Resume address for the running thread |
| ev_line | input | LINEW | Missed instruction line |
| fill_vld | input | 1 | Instruction line fill completed |
| fill_line | input | LINEW | Filled line index |
| wake_vld | input | 1 | Register value arrived for a thread |
| wake_tid | input | TIDW | Thread woken by the register arrival |
| run_vld | output | 1 | A thread is running |
| run_tid | output | TIDW | Running thread id |
| run_pc | output | PCW | Running thread program counter |
| run_win | output | WINW | Running thread window base |
| idle | output | 1 | Nothing running, nothing ready |
| fam_done | output | 1 | All threads of the family have ended |

## Verification
A corrupted ready order shows up at the very next dispatch as the wrong `run_tid` or a stale `run_pc`, two edges after the event that caused it. A lost wakeup or fill match leaves `idle` high or makes a thread disappear from the dispatch stream. The scoreboard sees this when its expected dispatch never arrives. A drifted live-thread count shows as `fam_done` rising early, or staying low one cycle after the final end tag.

// File: rtl/hts_pkg.sv
package hts_pkg;

  typedef enum logic [2:0] {
    TS_FREE   = 3'd0,
    TS_READY  = 3'd1,
    TS_RUN    = 3'd2,
    TS_WAIT_I = 3'd3,
    TS_WAIT_R = 3'd4,
    TS_KILL   = 3'd5
  } tstate_e;

  typedef enum logic [1:0] {
    TAG_SWCH  = 2'd0,
    TAG_END   = 2'd1,
    TAG_IMISS = 2'd2,
    TAG_RWAIT = 2'd3
  } evkind_e;

endpackage

// File: rtl/hts_slot.sv
module hts_slot
  import hts_pkg::*;
#(
  parameter int PCW   = 32,
  parameter int WINW  = 8,
  parameter int LINEW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc,
  input  logic [PCW-1:0]   cre_pc,
  input  logic [WINW-1:0]  cre_win,
  input  logic             ev_hit,
  input  logic [1:0]       ev_kind,
  input  logic [PCW-1:0]   ev_pc,
  input  logic [LINEW-1:0] ev_line,
  input  logic             fill_vld,
  input  logic [LINEW-1:0] fill_line,
  input  logic             wake_hit,
  input  logic             grant,
  output logic             free_o,
  output logic             ready_o,
  output logic             run_o,
  output logic             set_rdy_o,
  output logic [PCW-1:0]   pc_o,
  output logic [WINW-1:0]  win_o
);

  tstate_e          st_q, st_d;
  logic [PCW-1:0]   pc_q, pc_d;
  logic [WINW-1:0]  win_q;
  logic [LINEW-1:0] line_q;
  logic             pc_en, win_en, line_en;
  logic             same_fill;

  assign same_fill = fill_vld && (fill_line == ev_line);

  always_comb begin
    st_d    = st_q;
    pc_d    = ev_pc;
    pc_en   = 1'b0;
    win_en  = 1'b0;
    line_en = 1'b0;
    unique case (st_q)
      TS_FREE: begin
        if (alloc) begin
          st_d   = TS_READY;
          pc_d   = cre_pc;
          pc_en  = 1'b1;
          win_en = 1'b1;
        end
      end
      TS_READY: begin
        if (grant) st_d = TS_RUN;
      end
      TS_RUN: begin
        if (ev_hit) begin
          unique case (evkind_e'(ev_kind))
            TAG_SWCH: begin
              st_d  = TS_READY;
              pc_en = 1'b1;
            end
            TAG_END: st_d = TS_KILL;
            TAG_IMISS: begin
              st_d    = same_fill ? TS_READY : TS_WAIT_I;
              pc_en   = 1'b1;
              line_en = 1'b1;
            end
            TAG_RWAIT: begin
              st_d  = wake_hit ? TS_READY : TS_WAIT_R;
              pc_en = 1'b1;
            end
            default: st_d = st_q;
          endcase
        end
      end
      TS_WAIT_I: begin
        if (fill_vld && (fill_line == line_q)) st_d = TS_READY;
      end
      TS_WAIT_R: begin
        if (wake_hit) st_d = TS_READY;
      end
      TS_KILL: st_d = TS_FREE;
      default: st_d = TS_FREE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= TS_FREE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk) begin
    if (pc_en)   pc_q   <= pc_d;
    if (win_en)  win_q  <= cre_win;
    if (line_en) line_q <= ev_line;
  end

  assign free_o    = (st_q == TS_FREE);
  assign ready_o   = (st_q == TS_READY);
  assign run_o     = (st_q == TS_RUN);
  assign set_rdy_o = (st_d == TS_READY) && (st_q != TS_READY);
  assign pc_o      = pc_q;
  assign win_o     = win_q;

endmodule

// File: rtl/hts_age_pick.sv
module hts_age_pick #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] rdy,
  input  logic [N-1:0] set_rdy,
  output logic [N-1:0] gnt,
  output logic         any
);

  // older_q[i][j] = 1 : slot i entered the ready set before slot j
  logic [N-1:0][N-1:0] older_q, older_d;
  logic                upd;

  assign upd = |set_rdy;

  always_comb begin
    older_d = older_q;
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N; j++) begin
        if (set_rdy[i])      older_d[i][j] = set_rdy[j] && (i < j);
        else if (set_rdy[j]) older_d[i][j] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   older_q <= '0;
    else if (upd) older_q <= older_d;
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      logic blocked;
      blocked = 1'b0;
      for (int j = 0; j < N; j++) begin
        if ((j != i) && rdy[j] && older_q[j][i]) blocked = 1'b1;
      end
      gnt[i] = rdy[i] && !blocked;
    end
  end

  assign any = |rdy;

endmodule

// File: rtl/hts_fam_cnt.sv
module hts_fam_cnt #(
  parameter int N = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic dec,
  output logic done
);

  localparam int CW = $clog2(N + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_d, cnt_en;

  always_comb begin
    cnt_en = inc ^ dec;
    cnt_d  = cnt_q + CW'(inc) - CW'(dec);
    if (inc)                              done_d = 1'b0;
    else if (dec && (cnt_q == CW'(1)))    done_d = 1'b1;
    else                                  done_d = done;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      done  <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      done <= done_d;
    end
  end

endmodule

// File: rtl/hts_sched.sv
module hts_sched
  import hts_pkg::*;
#(
  parameter int  NTHR  = 16,
  parameter int  PCW   = 32,
  parameter int  WINW  = 8,
  parameter int  LINEW = 8,
  localparam int TIDW  = $clog2(NTHR)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cre_vld,
  input  logic [PCW-1:0]   cre_pc,
  input  logic [WINW-1:0]  cre_win,
  output logic             cre_room,
  input  logic             ev_vld,
  input  logic [1:0]       ev_kind,
  input  logic [PCW-1:0]   ev_pc,
  input  logic [LINEW-1:0] ev_line,
  input  logic             fill_vld,
  input  logic [LINEW-1:0] fill_line,
  input  logic             wake_vld,
  input  logic [TIDW-1:0]  wake_tid,
  output logic             run_vld,
  output logic [TIDW-1:0]  run_tid,
  output logic [PCW-1:0]   run_pc,
  output logic [WINW-1:0]  run_win,
  output logic             idle,
  output logic             fam_done
);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_s1, rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1  <= 1'b0;
      rst_n_s <= 1'b0;
    end else begin
      rst_s1  <= 1'b1;
      rst_n_s <= rst_s1;
    end
  end

  logic [NTHR-1:0] free_vec, rdy_vec, run_vec, set_rdy_vec;
  logic [NTHR-1:0] gnt_vec, alloc_vec;
  logic [PCW-1:0]  pc_arr  [NTHR];
  logic [WINW-1:0] win_arr [NTHR];
  logic            any_rdy, ev_take, disp, run_en, run_vld_d;
  logic [TIDW-1:0] run_tid_q, run_tid_d, gnt_tid;
  logic            run_vld_q;

  assign ev_take = ev_vld && run_vld_q;
  assign disp    = !run_vld_q && any_rdy;

  always_comb begin
    logic found;
    found     = 1'b0;
    alloc_vec = '0;
    for (int i = 0; i < NTHR; i++) begin
      if (!found && free_vec[i]) begin
        alloc_vec[i] = cre_vld;
        found        = 1'b1;
      end
    end
  end

  always_comb begin
    gnt_tid = '0;
    for (int i = 0; i < NTHR; i++) begin
      if (gnt_vec[i]) gnt_tid = TIDW'(i);
    end
  end

  for (genvar g = 0; g < NTHR; g++) begin : g_slot
    hts_slot #(
      .PCW  (PCW),
      .WINW (WINW),
      .LINEW(LINEW)
    ) u_slot (
      .clk      (clk),
      .rst_n    (rst_n_s),
      .alloc    (alloc_vec[g]),
      .cre_pc   (cre_pc),
      .cre_win  (cre_win),
      .ev_hit   (ev_take && (run_tid_q == TIDW'(g))),
      .ev_kind  (ev_kind),
      .ev_pc    (ev_pc),
      .ev_line  (ev_line),
      .fill_vld (fill_vld),
      .fill_line(fill_line),
      .wake_hit (wake_vld && (wake_tid == TIDW'(g))),
      .grant    (disp && gnt_vec[g]),
      .free_o   (free_vec[g]),
      .ready_o  (rdy_vec[g]),
      .run_o    (run_vec[g]),
      .set_rdy_o(set_rdy_vec[g]),
      .pc_o     (pc_arr[g]),
      .win_o    (win_arr[g])
    );
  end

  hts_age_pick #(.N(NTHR)) u_pick (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .rdy    (rdy_vec),
    .set_rdy(set_rdy_vec),
    .gnt    (gnt_vec),
    .any    (any_rdy)
  );

  hts_fam_cnt #(.N(NTHR)) u_fam (
    .clk  (clk),
    .rst_n(rst_n_s),
    .inc  (cre_vld && cre_room),
    .dec  (ev_take && (evkind_e'(ev_kind) == TAG_END)),
    .done (fam_done)
  );

  always_comb begin
    run_en    = ev_take || disp;
    run_vld_d = ev_take ? 1'b0 : disp;
    run_tid_d = disp ? gnt_tid : run_tid_q;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      run_vld_q <= 1'b0;
      run_tid_q <= '0;
    end else if (run_en) begin
      run_vld_q <= run_vld_d;
      run_tid_q <= run_tid_d;
    end
  end

  assign cre_room = |free_vec;
  assign run_vld  = run_vld_q;
  assign run_tid  = run_tid_q;
  assign run_pc   = pc_arr[run_tid_q];
  assign run_win  = win_arr[run_tid_q];
  assign idle     = !run_vld_q && !any_rdy;

endmodule

// File: rtl/hts_sched_chk.sv
module hts_sched_chk #(
  parameter int NTHR = 16,
  parameter int TIDW = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cre_vld,
  input logic            cre_room,
  input logic            ev_vld,
  input logic [1:0]      ev_kind,
  input logic            run_vld,
  input logic [TIDW-1:0] run_tid,
  input logic            idle,
  input logic            fam_done,
  input logic [NTHR-1:0] run_vec,
  input logic [NTHR-1:0] gnt_vec
);

  a_r9_idle_not_running: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !run_vld);

  a_r4_release_after_event: assert property (@(posedge clk) disable iff (!rst_n)
    (run_vld && ev_vld) |=> !run_vld);

  a_r3_dispatch_next: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_vld && !idle) |=> run_vld);

  a_r3_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_vec));

  a_r4_single_runner: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(run_vec) && (run_vld == (|run_vec)));

  a_r4_runner_matches_id: assert property (@(posedge clk) disable iff (!rst_n)
    run_vld |-> run_vec[run_tid]);

  a_r10_done_after_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fam_done) |-> $past(run_vld && ev_vld && (ev_kind == 2'd1)));

  a_r10_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (fam_done && cre_vld && cre_room) |=> !fam_done);

endmodule

bind hts_sched hts_sched_chk #(.NTHR(NTHR), .TIDW(TIDW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n_s),
  .cre_vld (cre_vld),
  .cre_room(cre_room),
  .ev_vld  (ev_vld),
  .ev_kind (ev_kind),
  .run_vld (run_vld),
  .run_tid (run_tid),
  .idle    (idle),
  .fam_done(fam_done),
  .run_vec (run_vec),
  .gnt_vec (gnt_vec)
);

// File: tb/hts_sched_bench.sv
module hts_sched_bench;

  localparam int NTHR = 16, PCW = 32, WINW = 8, LINEW = 8, TIDW = 4;

  typedef struct packed {
    logic [TIDW-1:0] tid;
    logic [PCW-1:0]  pc;
    logic [WINW-1:0] win;
  } disp_t;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             cre_vld, cre_room;
  logic [PCW-1:0]   cre_pc;
  logic [WINW-1:0]  cre_win;
  logic             ev_vld;
  logic [1:0]       ev_kind;
  logic [PCW-1:0]   ev_pc;
  logic [LINEW-1:0] ev_line;
  logic             fill_vld;
  logic [LINEW-1:0] fill_line;
  logic             wake_vld;
  logic [TIDW-1:0]  wake_tid;
  logic             run_vld, idle, fam_done;
  logic [TIDW-1:0]  run_tid;
  logic [PCW-1:0]   run_pc;
  logic [WINW-1:0]  run_win;

  int    total = 0, bad = 0;
  bit    fin = 0;
  bit    prev_vld = 0;
  disp_t exp_q[$];

  always #10 clk = ~clk;

  hts_sched #(.NTHR(NTHR), .PCW(PCW), .WINW(WINW), .LINEW(LINEW)) u_hts_sched (
    .clk(clk), .rst_n(rst_n),
    .cre_vld(cre_vld), .cre_pc(cre_pc), .cre_win(cre_win), .cre_room(cre_room),
    .ev_vld(ev_vld), .ev_kind(ev_kind), .ev_pc(ev_pc), .ev_line(ev_line),
    .fill_vld(fill_vld), .fill_line(fill_line),
    .wake_vld(wake_vld), .wake_tid(wake_tid),
    .run_vld(run_vld), .run_tid(run_tid), .run_pc(run_pc), .run_win(run_win),
    .idle(idle), .fam_done(fam_done)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic expect_disp(input int tid, input logic [PCW-1:0] pc, input logic [WINW-1:0] win);
    disp_t e;
    e.tid = TIDW'(tid);
    e.pc  = pc;
    e.win = win;
    exp_q.push_back(e);
  endtask

  task automatic create(input logic [PCW-1:0] pc, input logic [WINW-1:0] win);
    cre_vld = 1'b1; cre_pc = pc; cre_win = win;
    tick();
    cre_vld = 1'b0;
  endtask

  task automatic tag(input logic [1:0] kind, input logic [PCW-1:0] pc, input logic [LINEW-1:0] line);
    ev_vld = 1'b1; ev_kind = kind; ev_pc = pc; ev_line = line;
    tick();
    ev_vld = 1'b0;
  endtask

  task automatic wait_run();
    for (int k = 0; k < 8 && !run_vld; k++) tick();
  endtask

  // monitor: each new dispatch is compared with the head of the scoreboard
  always @(negedge clk) begin
    if (rst_n && run_vld && !prev_vld) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R3 unexpected dispatch", {run_tid, run_pc, run_win}, 0);
      end else begin
        disp_t e;
        e = exp_q.pop_front();
        chk((run_tid == e.tid) && (run_pc == e.pc) && (run_win == e.win),
            "R3 dispatch order and context", {run_tid, run_pc, run_win}, e);
      end
    end
    prev_vld = run_vld;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!fin) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    cre_vld = 0; cre_pc = 0; cre_win = 0;
    ev_vld = 0; ev_kind = 0; ev_pc = 0; ev_line = 0;
    fill_vld = 0; fill_line = 0; wake_vld = 0; wake_tid = 0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (3) tick();

    // R1 reset state
    chk(!run_vld, "R1 run_vld", run_vld, 0);
    chk(idle, "R1 idle", idle, 1);
    chk(!fam_done, "R1 fam_done", fam_done, 0);
    chk(cre_room, "R1 cre_room", cre_room, 1);

    // R2 creation into slots 0,1,2
    expect_disp(0, 32'h100, 8'd0);
    create(32'h100, 8'd0);
    create(32'h200, 8'd8);
    create(32'h300, 8'd16);
    tick();
    chk(run_vld && run_tid == 0, "R2 first created thread runs", run_tid, 0);
    chk(!idle, "R9 not idle while running", idle, 0);

    // R4 switch tag: two-edge latency, thread goes to tail
    expect_disp(1, 32'h200, 8'd8);
    tag(2'd0, 32'h104, 8'd0);
    chk(!run_vld, "R4 run_vld low after first edge", run_vld, 0);
    tick();
    chk(run_vld && run_tid == 1, "R4 next thread after second edge", run_tid, 1);

    // R7 register wait parks thread 1
    expect_disp(2, 32'h300, 8'd16);
    tag(2'd3, 32'h208, 8'd0);
    tick();
    // R6 instruction miss parks thread 2 on line 5
    expect_disp(0, 32'h104, 8'd0);
    tag(2'd2, 32'h310, 8'd5);
    tick();
    tag(2'd2, 32'h120, 8'd5);
    chk(idle && !run_vld, "R9 idle with all parked", idle, 1);

    // R11 event with nothing running
    tag(2'd0, 32'h999, 8'd0);
    chk(idle && !run_vld, "R11 event ignored when idle", idle, 1);
    // R7 wakeup to a thread parked on a line
    wake_vld = 1'b1; wake_tid = 4'd2;
    tick();
    wake_vld = 1'b0;
    chk(idle, "R7 wakeup to non-register waiter ignored", idle, 1);
    // R6 fill for another line
    fill_vld = 1'b1; fill_line = 8'd3;
    tick();
    fill_vld = 1'b0;
    chk(idle, "R6 fill of other line ignored", idle, 1);

    // R6 fill wakes both slot 0 and slot 2, lower index first (R3)
    expect_disp(0, 32'h120, 8'd0);
    fill_vld = 1'b1; fill_line = 8'd5;
    tick();
    fill_vld = 1'b0;
    tick();
    chk(run_vld && run_tid == 0 && run_pc == 32'h120, "R6 matching fill wakes waiters", run_pc, 32'h120);

    // R7 wakeup of thread 1 while 0 runs; order then 2,1,0
    wake_vld = 1'b1; wake_tid = 4'd1;
    tick();
    wake_vld = 1'b0;
    expect_disp(2, 32'h310, 8'd16);
    expect_disp(1, 32'h208, 8'd8);
    expect_disp(0, 32'h124, 8'd0);
    tag(2'd0, 32'h124, 8'd0);
    tick();
    chk(run_tid == 2, "R3 oldest ready first", run_tid, 2);
    tag(2'd1, 32'h0, 8'd0);
    tick();
    chk(run_tid == 1, "R7 woken thread dispatched", run_tid, 1);
    tag(2'd1, 32'h0, 8'd0);
    tick();
    chk(run_tid == 0 && !fam_done, "R10 no done while thread lives", fam_done, 0);

    // R8 same-cycle wakeup and fill
    expect_disp(0, 32'h130, 8'd0);
    ev_vld = 1'b1; ev_kind = 2'd3; ev_pc = 32'h130;
    wake_vld = 1'b1; wake_tid = 4'd0;
    tick();
    ev_vld = 1'b0; wake_vld = 1'b0;
    tick();
    chk(run_vld && run_pc == 32'h130, "R8 register wait with same-cycle wakeup", run_pc, 32'h130);
    expect_disp(0, 32'h140, 8'd0);
    ev_vld = 1'b1; ev_kind = 2'd2; ev_pc = 32'h140; ev_line = 8'd9;
    fill_vld = 1'b1; fill_line = 8'd9;
    tick();
    ev_vld = 1'b0; fill_vld = 1'b0;
    tick();
    chk(run_vld && run_pc == 32'h140, "R8 miss with same-cycle fill", run_pc, 32'h140);

    // R5 freed slot reused by a later create
    expect_disp(1, 32'h500, 8'd24);
    create(32'h500, 8'd24);
    chk(cre_room, "R2 room remains", cre_room, 1);
    tag(2'd1, 32'h0, 8'd0);
    tick();
    chk(run_vld && run_tid == 1, "R5 ended slot reallocated", run_tid, 1);
    chk(!fam_done, "R10 done low with one live thread", fam_done, 0);
    tag(2'd1, 32'h0, 8'd0);
    chk(fam_done, "R10 done after last end", fam_done, 1);
    chk(idle, "R9 idle after family ends", idle, 1);

    // R2 fill the whole table
    expect_disp(0, 32'h1000, 8'd0);
    create(32'h1000, 8'd0);
    chk(!fam_done, "R10 done cleared by create", fam_done, 0);
    for (int i = 1; i < NTHR; i++) begin
      expect_disp(i, 32'h1000 + 32'(i * 4), 8'(i * 8));
      create(32'h1000 + 32'(i * 4), 8'(i * 8));
    end
    chk(!cre_room, "R2 table full", cre_room, 0);
    create(32'hdead, 8'd1);
    for (int i = 0; i < NTHR; i++) begin
      wait_run();
      tag(2'd1, 32'h0, 8'd0);
    end
    tick();
    chk(fam_done && idle, "R2 create with full table ignored", {fam_done, idle}, 2'b11);
    chk(exp_q.size() == 0, "R3 all expected dispatches seen", exp_q.size(), 0);

    fin = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule